// File: doc/BRIEF.md
# Per-Sector ECC Status Checker

After a flash page has been read into a buffer slot, this block decides whether the page can be used. The flash controller holds one 4-bit ECC status code for every 512-byte sector. Four codes share one 32-bit status word, and sector 0 of a word sits in its most significant byte. The block is told the page size and the buffer slot. It waits for the read-complete bit in the controller's event status. It then walks the slot's sectors in ascending order, reading only the status words that cover them.

A code of 0xF marks an uncorrectable sector. An erased page always fails the hardware check, so an uncorrectable sector does not condemn the page at once. Instead the block scans the page's main-area bytes in the buffer, one per cycle. If every byte is 0xFF, the page is reported blank and no further sectors are examined. The first byte that is not 0xFF raises a fatal result, and the block then halts until reset.

A passing or blank outcome writes the captured event status back so that it clears. The outcome is also reported as a one-cycle done pulse with a one-hot result flag.

Top module: `sector_ecc_judge`

## Requirements
- R1: After reset, done, pass, blank, fatal, evt_we, halted, stat_re and page_re are all low.
- R2: A start pulse is accepted only while idle. It captures page_sel and slot. No status word is read until evt_stat bit 31 has been seen high. That whole event word is captured in the cycle it is seen.
- R3: Only the status words with indices first/4 through last/4 are read, where first and last are the slot's first and last sector numbers.
- R4: The code of sector n is bits [(3 − n mod 4)·8 +: 4] of status word n/4. The upper nibble of each byte is ignored.
- R5: Any code other than 0xF is acceptable. When every sector of the range is acceptable, pass is reported.
- R6: page_sel 0, 1, 2 and 3 select pages of 512, 2048, 4096 and 8192 bytes, which hold 1, 4, 8 and 16 sectors. The first sector is (slot × sectors) mod 32, so slot bits beyond the range are ignored. The sectors are examined in ascending order, one per cycle.
- R7: The first sector with code 0xF stops the sector walk and starts a scan of the page's main area. That area is byte addresses first·1024 through first·1024 + page_bytes − 1. If all of those bytes are 0xFF, blank is reported, and bytes beyond the main area are never read.
- R8: If the scan meets a byte that is not 0xFF, fatal is reported with done. halted then stays high until reset, start and events are ignored, and no event write-back occurs.
- R9: done is a one-cycle pulse with exactly one of pass, blank or fatal. On pass or blank, evt_we pulses in the same cycle with evt_wdata equal to the captured event word.
- R10: The byte scan ends at the first byte that is not 0xFF. No byte after it is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a check (accepted when idle) |
| page_sel | input | 2 | Page size code: 0=512, 1=2048, 2=4096, 3=8192 bytes |
| slot | input | 5 | Buffer slot number |
| evt_stat | input | 32 | Controller event status; bit 31 = read complete |
| stat_re | output | 1 | Status word read strobe |
| stat_addr | output | 3 | Status word index |
| stat_rdata | input | 32 | Status word (combinational read) |
| page_re | output | 1 | Page byte read strobe |
| page_addr | output | 15 | Buffer byte address |
| page_rdata | input | 8 | Buffer byte (combinational read) |
| evt_we | output | 1 | Event status write-back strobe |
| evt_wdata | output | 32 | Captured event word to write back |
| done | output | 1 | Result valid pulse |
| pass | output | 1 | Page usable |
| blank | output | 1 | Page erased |
| fatal | output | 1 | Uncorrectable page with data |
| halted | output | 1 | Block stopped after fatal |

## Verification
Two functions can coincide in one cycle when the non-0xFF byte is the very last byte of the main area. The end-of-scan decision and the mismatch decision then fall together, and fatal must win over blank. This is provoked by placing a single 0x00 at the final main-area address of a 2048-byte page. It is judged by a fatal result with no write-back, a byte-read count equal to the full page, and a sticky halt. The write-back and the result pulse are a second pair that always share a cycle. Every pass or blank run checks that evt_we and done are sampled high together.

// File: rtl/sej_pkg.sv
package sej_pkg;

    localparam int LG_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WAIT  = 3'd1,
        ST_SCAN  = 3'd2,
        ST_BLANK = 3'd3,
        ST_HALT  = 3'd4
    } st_e;

    // log2 of sectors per page for each page size code
    function automatic logic [LG_W-1:0] sectors_lg(input logic [1:0] psel);
        case (psel)
            2'd0:    sectors_lg = 3'd0;
            2'd1:    sectors_lg = 3'd2;
            2'd2:    sectors_lg = 3'd3;
            default: sectors_lg = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/sej_range.sv
module sej_range
    import sej_pkg::*;
#(
    parameter int SEC_W = 5
) (
    input  logic [1:0]       page_sel,
    input  logic [SEC_W-1:0] slot,
    output logic [SEC_W-1:0] first,
    output logic [SEC_W-1:0] last,
    output logic [LG_W-1:0]  lg
);
    logic [SEC_W-1:0] span_m1;

    always_comb begin
        lg      = sectors_lg(page_sel);
        // shifting in SEC_W bits drops slot bits beyond the range
        first   = slot << lg;
        span_m1 = SEC_W'((1 << lg) - 1);
        last    = first + span_m1;
    end
endmodule

// File: rtl/sej_nibble.sv
module sej_nibble #(
    parameter int WORD_W = 32,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int NIB_W  = 4,
    localparam int LIDX_W = $clog2(LANES)
) (
    input  logic [WORD_W-1:0] word,
    input  logic [LIDX_W-1:0] lane,
    output logic              uncorr
);
    logic [NIB_W-1:0] lane_nib [LANES];

    // lane 0 lives in the most significant byte
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_nib[g] = word[(LANES-1-g)*LANE_W +: NIB_W];
    end

    assign uncorr = &lane_nib[lane];
endmodule

// File: rtl/sector_ecc_judge.sv
module sector_ecc_judge
    import sej_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int STAT_WORDS   = 8,
    parameter int WORD_W       = 32,
    parameter int LANES        = 4,
    parameter int LANE_W       = 8,
    parameter int NIB_W        = 4,
    parameter int MAX_SPP      = 16,
    parameter int DONE_BIT     = 31,
    localparam int MAX_SEC  = STAT_WORDS * LANES,
    localparam int SEC_W    = $clog2(MAX_SEC),
    localparam int LIDX_W   = $clog2(LANES),
    localparam int WADDR_W  = $clog2(STAT_WORDS),
    localparam int IDX_W    = $clog2(MAX_SPP * SECTOR_BYTES),
    localparam int BADDR_W  = $clog2(MAX_SEC * SECTOR_BYTES * 2),
    localparam int SLOT_SH  = $clog2(SECTOR_BYTES) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         page_sel,
    input  logic [SEC_W-1:0]   slot,
    input  logic [WORD_W-1:0]  evt_stat,
    output logic               stat_re,
    output logic [WADDR_W-1:0] stat_addr,
    input  logic [WORD_W-1:0]  stat_rdata,
    output logic               page_re,
    output logic [BADDR_W-1:0] page_addr,
    input  logic [7:0]         page_rdata,
    output logic               evt_we,
    output logic [WORD_W-1:0]  evt_wdata,
    output logic               done,
    output logic               pass,
    output logic               blank,
    output logic               fatal,
    output logic               halted
);
    typedef struct packed {
        st_e              st;
        logic [1:0]       psel;
        logic [SEC_W-1:0] slot;
        logic [SEC_W-1:0] sec;
        logic [IDX_W-1:0] idx;
        logic [WORD_W-1:0] evt;
        logic             done;
        logic             pass;
        logic             blank;
        logic             fatal;
        logic             evt_we;
    } regs_t;

    regs_t r_q, r_d;

    logic [SEC_W-1:0] first_w, last_w;
    logic [LG_W-1:0]  lg_w;
    logic [IDX_W-1:0] page_last_w;
    logic             uncorr_w;

    sej_range #(.SEC_W(SEC_W)) u_range (
        .page_sel (r_q.psel),
        .slot     (r_q.slot),
        .first    (first_w),
        .last     (last_w),
        .lg       (lg_w)
    );

    sej_nibble #(
        .WORD_W (WORD_W),
        .LANES  (LANES),
        .LANE_W (LANE_W),
        .NIB_W  (NIB_W)
    ) u_nib (
        .word   (stat_rdata),
        .lane   (r_q.sec[LIDX_W-1:0]),
        .uncorr (uncorr_w)
    );

    assign page_last_w = IDX_W'((SECTOR_BYTES << lg_w) - 1);

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        r_d.pass   = 1'b0;
        r_d.blank  = 1'b0;
        r_d.fatal  = 1'b0;
        r_d.evt_we = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.psel = page_sel;
                    r_d.slot = slot;
                    r_d.st   = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (evt_stat[DONE_BIT]) begin
                    r_d.evt = evt_stat;
                    r_d.sec = first_w;
                    r_d.st  = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (uncorr_w) begin
                    r_d.idx = '0;
                    r_d.st  = ST_BLANK;
                end else if (r_q.sec == last_w) begin
                    r_d.done   = 1'b1;
                    r_d.pass   = 1'b1;
                    r_d.evt_we = 1'b1;
                    r_d.st     = ST_IDLE;
                end else begin
                    r_d.sec = r_q.sec + 1'b1;
                end
            end
            ST_BLANK: begin
                // a mismatch on the last byte still counts as fatal
                if (page_rdata != 8'hFF) begin
                    r_d.done  = 1'b1;
                    r_d.fatal = 1'b1;
                    r_d.st    = ST_HALT;
                end else if (r_q.idx == page_last_w) begin
                    r_d.done   = 1'b1;
                    r_d.blank  = 1'b1;
                    r_d.evt_we = 1'b1;
                    r_d.st     = ST_IDLE;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            ST_HALT: r_d.st = ST_HALT;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign stat_re   = (r_q.st == ST_SCAN);
    assign stat_addr = r_q.sec[SEC_W-1:LIDX_W];
    assign page_re   = (r_q.st == ST_BLANK);
    assign page_addr = (BADDR_W'(first_w) << SLOT_SH) + BADDR_W'(r_q.idx);
    assign evt_we    = r_q.evt_we;
    assign evt_wdata = r_q.evt;
    assign done      = r_q.done;
    assign pass      = r_q.pass;
    assign blank     = r_q.blank;
    assign fatal     = r_q.fatal;
    assign halted    = (r_q.st == ST_HALT);

    assert_result_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot({pass, blank, fatal}));

    assert_result_needs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pass || blank || fatal) |-> done);

    assert_writeback_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_we |-> (done && !fatal && evt_wdata[DONE_BIT]));

    assert_scan_after_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_re) |-> $past(evt_stat[DONE_BIT]));

    assert_word_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stat_re |-> ((stat_addr >= WADDR_W'(first_w >> LIDX_W)) &&
                     (stat_addr <= WADDR_W'(last_w >> LIDX_W))));

    assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !done && !evt_we));

    assert_fatal_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |-> $past(page_re && (page_rdata != 8'hFF)));

    assert_blank_ends_walk_R7: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> (!stat_re && !page_re));
endmodule

// File: tb/tb_sector_ecc_judge.sv
`timescale 1ns/100ps
module tb_sector_ecc_judge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  page_sel = 2'd0;
    logic [4:0]  slot = 5'd0;
    logic [31:0] evt_stat = 32'd0;
    logic        stat_re, page_re, evt_we, done, pass, blank, fatal, halted;
    logic [2:0]  stat_addr;
    logic [31:0] stat_rdata, evt_wdata;
    logic [14:0] page_addr;
    logic [7:0]  page_rdata;

    logic [31:0] smem [8];
    logic        bad_en = 1'b0;
    int          bad_abs = 0;
    int          spare_abs = 0;

    int n_chk = 0;
    int n_bad = 0;

    // monitor counters (written only by the monitor)
    int sr_cnt = 0, pr_cnt = 0, oob_cnt = 0, early_cnt = 0;
    int win_lo = 0, win_hi = 7;
    logic evt_given = 1'b0;

    always #2.5 clk = ~clk;

    assign stat_rdata = smem[stat_addr];
    assign page_rdata = (bad_en && int'(page_addr) == bad_abs) ? 8'h00 :
                        (int'(page_addr) == spare_abs) ? 8'h00 : 8'hFF;

    sector_ecc_judge dut (
        .clk(clk), .rst_n(rst_n), .start(start), .page_sel(page_sel), .slot(slot),
        .evt_stat(evt_stat), .stat_re(stat_re), .stat_addr(stat_addr),
        .stat_rdata(stat_rdata), .page_re(page_re), .page_addr(page_addr),
        .page_rdata(page_rdata), .evt_we(evt_we), .evt_wdata(evt_wdata),
        .done(done), .pass(pass), .blank(blank), .fatal(fatal), .halted(halted)
    );

    always @(negedge clk) begin
        if (stat_re) begin
            sr_cnt++;
            if (int'(stat_addr) < win_lo || int'(stat_addr) > win_hi) oob_cnt++;
            if (!evt_given) early_cnt++;
        end
        if (page_re) pr_cnt++;
    end

    typedef struct packed {
        int psel; int slot; int brel; int bnib; int fill; int boff; int exp;
    } vec_t;

    // exp: 0 pass, 1 blank, 2 fatal; brel -1 = no marked sector; boff -1 = all 0xFF
    localparam vec_t VEC [10] = '{
        '{0,  3, -1,  0,  0,   -1, 0},
        '{1,  2, -1,  0, 14,   -1, 0},
        '{2,  1,  5, 15,  0,   -1, 1},
        '{3,  1,  0, 15,  1,   -1, 1},
        '{3,  3, -1,  0,  7,   -1, 0},
        '{2,  2,  2, 14,  3,   -1, 0},
        '{1,  0,  1, 15,  0,   -1, 1},
        '{1,  7,  3, 15,  0, 2047, 2},
        '{0, 31,  0, 15,  0,    0, 2},
        '{2,  0,  7, 15,  9,  100, 2}
    };

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        start = 1'b0;
        evt_stat = 32'd0;
        evt_given = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({done, pass, blank, fatal, evt_we, halted, stat_re, page_re} == 8'd0,
            "R1", "outputs after reset",
            {done, pass, blank, fatal, evt_we, halted, stat_re, page_re}, 0);
    endtask

    task automatic run_vec(input int i);
        vec_t v;
        int lg, spp, first, last, exp_sr, exp_pr, sr0, pr0, oob0, early0, res;
        logic [3:0] nib;
        logic [31:0] evt_word;
        bit seen;
        string rq;
        v = VEC[i];
        lg = (v.psel == 0) ? 0 : (v.psel == 1) ? 2 : (v.psel == 2) ? 3 : 4;
        spp = 1 << lg;
        first = (v.slot * spp) % 32;
        last = first + spp - 1;
        for (int w = 0; w < 8; w++) smem[w] = 32'd0;
        for (int s = 0; s < 32; s++) begin
            if (s < first || s > last) nib = 4'hF;
            else if (v.brel >= 0 && s == first + v.brel) nib = v.bnib[3:0];
            else nib = v.fill[3:0];
            smem[s / 4][(3 - s % 4) * 8 +: 8] = {4'hA, nib};
        end
        bad_en = (v.boff >= 0);
        bad_abs = first * 1024 + v.boff;
        spare_abs = first * 1024 + spp * 512;
        win_lo = first / 4;
        win_hi = last / 4;
        if (v.brel >= 0 && v.bnib == 15) begin
            exp_sr = v.brel + 1;
            exp_pr = (v.boff >= 0) ? v.boff + 1 : spp * 512;
        end else begin
            exp_sr = spp;
            exp_pr = 0;
        end
        sr0 = sr_cnt; pr0 = pr_cnt; oob0 = oob_cnt; early0 = early_cnt;

        @(negedge clk);
        start = 1'b1;
        page_sel = v.psel[1:0];
        slot = v.slot[4:0];
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        evt_word = 32'h8000_0000 | (32'(i) << 8) | 32'h5A;
        evt_stat = evt_word;
        evt_given = 1'b1;
        seen = 1'b0;
        for (int k = 0; k < 20000 && !seen; k++) begin
            @(negedge clk);
            if (done) seen = 1'b1;
        end
        chk(seen, "R9", "done pulse seen", seen, 1);
        res = fatal ? 2 : blank ? 1 : pass ? 0 : 3;
        if (v.exp == 0) rq = (v.brel >= 0) ? "R5" : "R4";
        else if (v.exp == 1) rq = "R7";
        else rq = "R8";
        chk(res == v.exp, rq, $sformatf("vector %0d result", i), res, v.exp);
        chk(evt_we == (v.exp != 2), "R9", "write-back strobe", evt_we, v.exp != 2);
        if (v.exp != 2)
            chk(evt_wdata == evt_word, "R9", "write-back data", evt_wdata, evt_word);
        chk(sr_cnt - sr0 == exp_sr, "R6", $sformatf("vector %0d sectors examined", i),
            sr_cnt - sr0, exp_sr);
        chk(pr_cnt - pr0 == exp_pr, "R10", $sformatf("vector %0d bytes read", i),
            pr_cnt - pr0, exp_pr);
        chk(oob_cnt == oob0, "R3", "status word outside range", oob_cnt - oob0, 0);
        chk(early_cnt == early0, "R2", "status read before event", early_cnt - early0, 0);
        @(negedge clk);
        chk({done, pass, blank, fatal, evt_we} == 5'd0, "R9", "result lasts one cycle",
            {done, pass, blank, fatal, evt_we}, 0);
        evt_stat = 32'd0;
        evt_given = 1'b0;

        if (v.exp == 2) begin
            chk(halted, "R8", "halted after fatal", halted, 1);
            sr0 = sr_cnt;
            seen = 1'b0;
            start = 1'b1;
            evt_stat = 32'h8000_0001;
            evt_given = 1'b1;
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                start = 1'b0;
                if (done || evt_we) seen = 1'b1;
            end
            chk(!seen && sr_cnt == sr0, "R8", "activity while halted", seen, 0);
            chk(halted, "R8", "halt is sticky", halted, 1);
            evt_stat = 32'd0;
            evt_given = 1'b0;
            do_reset();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int w = 0; w < 8; w++) smem[w] = 32'd0;
        do_reset();
        // R2: no status read without the read-complete bit
        begin
            int sr0;
            sr0 = sr_cnt;
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            evt_stat = 32'h7FFF_FFFF;
            repeat (10) @(negedge clk);
            chk(sr_cnt == sr0 && !done, "R2", "walk began without event bit",
                sr_cnt - sr0, 0);
            do_reset();
        end
        for (int i = 0; i < 10; i++) run_vec(i);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule